// File: doc/BRIEF.md
# Floating-Point Register Block Transfer Sequencer

The sequencer takes one floating-point load-multiple or store-multiple command and turns it into a stream of 32-bit word-transfer micro-ops, followed where needed by one base-register update micro-op. A command carries an 8-bit word-count field, a first FP register index, a precision flag, a direction flag, a writeback request and a load/store select.

Each micro-op leaves on a valid/ready handshake and carries:
- a kind code;
- an FP register index;
- a signed byte offset from the base, or the base-update amount for the update op;
- a last marker.

When the count field decodes to zero, or to more elements than the FP register file holds, the block raises a malformed-count flag. A count that is too large is clamped to the register file size. A zero count always yields a base update, so the sequence is never empty. Sequences longer than the micro-op limit are cut short, and the cut is reported.

The control is a three-state machine:
- `ST_IDLE` accepts a command. On acceptance it goes to `ST_XFER` when there is at least one word transfer, or straight to `ST_BASE` when there is none.
- `ST_XFER` emits one word transfer per handshake. After the final allowed micro-op it returns to `ST_IDLE`. After the last transfer, with a base update still pending, it moves to `ST_BASE`.
- `ST_BASE` emits the base update and returns to `ST_IDLE` on its handshake.

Top module: `fp_block_xfer_seq`

## Requirements
- R1: A command is taken only on a cycle where `cmd_valid_i` and `cmd_ready_o` are both high. `cmd_ready_o` is high exactly when no sequence is in progress, and a command offered while busy has no effect on the running sequence. While `uop_valid_o` is high and `uop_ready_i` is low, every micro-op output holds its value.
- R2: The element count is the count field when `cmd_single_i`=1, and the field shifted right by one when it is 0. A single element gives one word transfer; a double element gives two word transfers.
- R3: `bad_count_o` goes high in the cycle after acceptance when the element count is 0 or greater than 32. It holds until the next acceptance and is 0 after reset.
- R4: An element count above 32 is treated as 32.
- R5: An element count of 0 produces a base-update micro-op even when `cmd_wb_i`=0.
- R6: The first transfer has offset −4×field when `cmd_dir_i`=1 and 0 when it is 0. Each later transfer's offset is 4 greater than the one before, so the two words of a double element sit at addr and addr+4.
- R7: The first transfer uses `cmd_reg_i` as its register index. Each later transfer uses the previous index plus 1, modulo 32.
- R8: Kind codes are 0 for load word, 1 for store word, 2 for base add and 3 for base subtract. The base update comes after all transfers. It adds when `cmd_dir_i`=1 and subtracts otherwise, carries 4×field on `uop_ofs_o`, and carries 0 on `uop_reg_o`.
- R9: No sequence has more than 17 micro-ops. When the full sequence would be longer, only its first 17 are emitted, and `limit_hit_o` is high from the cycle after acceptance until the next acceptance.
- R10: `uop_last_o` is high on exactly the final micro-op of a sequence. `cmd_ready_o` is high in the cycle after that micro-op's handshake.
- R11: After reset, `cmd_ready_o`=1, `uop_valid_o`=0, `bad_count_o`=0 and `limit_hit_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Sequencer idle, command accepted when valid |
| cmd_field_i | input | 8 | Word-count field |
| cmd_reg_i | input | 5 | First FP register index |
| cmd_single_i | input | 1 | 1 = single-precision elements, 0 = double |
| cmd_dir_i | input | 1 | Direction: 1 = negative start offset and base add |
| cmd_wb_i | input | 1 | Request base update |
| cmd_load_i | input | 1 | 1 = load, 0 = store |
| uop_valid_o | output | 1 | Micro-op present |
| uop_ready_i | input | 1 | Consumer takes micro-op |
| uop_kind_o | output | 2 | Micro-op kind code (R8) |
| uop_reg_o | output | 5 | FP register index |
| uop_ofs_o | output | 12 | Signed byte offset, or update amount |
| uop_last_o | output | 1 | Final micro-op of the sequence |
| bad_count_o | output | 1 | Malformed count field in last command |
| limit_hit_o | output | 1 | Last command's sequence was truncated |

## Verification
A command taken at a rising edge shows its first micro-op, `bad_count_o` and `limit_hit_o` one cycle later. Each later micro-op appears one cycle after the handshake of the one before it, and `cmd_ready_o` returns one cycle after the handshake of the last one. The bench drives inputs on the falling edge and samples on the falling edge after each rising edge. Every sampled value therefore reflects exactly the edges that have passed. A micro-op is recorded only on a falling edge where valid and ready are both high. While the consumer stalls, the outputs are compared with those of the previous falling edge.

// File: rtl/fpbt_pkg.sv
package fpbt_pkg;

    // R8: micro-op kind encoding
    typedef enum logic [1:0] {
        UOP_LOAD_WORD  = 2'd0,
        UOP_STORE_WORD = 2'd1,
        UOP_BASE_ADD   = 2'd2,
        UOP_BASE_SUB   = 2'd3
    } uop_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_BASE = 2'd2
    } seq_state_e;

    localparam int unsigned WORD_BYTES = 4;

endpackage

// File: rtl/fpbt_count_decode.sv
module fpbt_count_decode #(
    parameter int unsigned FIELD_W     = 8,
    parameter int unsigned NUM_FP_REGS = 32,
    parameter int unsigned MAX_UOPS    = 17,
    parameter int unsigned OFS_W       = 12,
    localparam int unsigned ELEM_W     = $clog2(NUM_FP_REGS + 1),
    localparam int unsigned XFER_W     = $clog2(2 * NUM_FP_REGS + 1),
    localparam int unsigned TOT_W      = XFER_W + 1
) (
    input  logic [FIELD_W-1:0]      field_i,
    input  logic                    single_i,
    input  logic                    dir_i,
    input  logic                    wb_i,
    output logic                    bad_o,
    output logic [XFER_W-1:0]       nxfer_o,
    output logic                    do_wb_o,
    output logic [TOT_W-1:0]        emit_o,
    output logic                    limit_hit_o,
    output logic signed [OFS_W-1:0] start_ofs_o,
    output logic signed [OFS_W-1:0] imm_o
);

    logic [FIELD_W-1:0] elem_raw;
    logic               elem_zero;
    logic               elem_over;
    logic [ELEM_W-1:0]  elem;
    logic [TOT_W-1:0]   total;

    always_comb begin
        // R2: double precision halves the field
        elem_raw  = single_i ? field_i : (field_i >> 1);
        elem_zero = (elem_raw == '0);
        elem_over = (elem_raw > FIELD_W'(NUM_FP_REGS));
        // R3: malformed count
        bad_o     = elem_zero | elem_over;
        // R4: clamp
        elem      = elem_over ? ELEM_W'(NUM_FP_REGS) : ELEM_W'(elem_raw);
        nxfer_o   = single_i ? XFER_W'(elem) : (XFER_W'(elem) << 1);
        // R5: zero count forces base update
        do_wb_o   = wb_i | elem_zero;
        total     = TOT_W'(nxfer_o) + TOT_W'(do_wb_o);
        // R9: length limit
        limit_hit_o = (total > TOT_W'(MAX_UOPS));
        emit_o      = limit_hit_o ? TOT_W'(MAX_UOPS) : total;
        // R6 / R8: start offset and update amount
        imm_o       = OFS_W'({field_i, 2'b00});
        start_ofs_o = dir_i ? -imm_o : '0;
    end

endmodule

// File: rtl/fpbt_walker.sv
module fpbt_walker #(
    parameter int unsigned REG_W = 5,
    parameter int unsigned OFS_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_i,
    input  logic                    step_i,
    input  logic [REG_W-1:0]        reg_start_i,
    input  logic signed [OFS_W-1:0] ofs_start_i,
    output logic [REG_W-1:0]        reg_o,
    output logic signed [OFS_W-1:0] ofs_o
);

    localparam logic signed [OFS_W-1:0] OFS_STEP = OFS_W'(fpbt_pkg::WORD_BYTES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_o <= '0;
            ofs_o <= '0;
        end else if (load_i) begin
            reg_o <= reg_start_i;
            ofs_o <= ofs_start_i;
        end else if (step_i) begin
            // R7: index wraps naturally at 2**REG_W
            reg_o <= reg_o + REG_W'(1);
            // R6: one word further per transfer
            ofs_o <= ofs_o + OFS_STEP;
        end
    end

endmodule

// File: rtl/fp_block_xfer_seq.sv
module fp_block_xfer_seq #(
    parameter int unsigned FIELD_W     = 8,
    parameter int unsigned REG_W       = 5,
    parameter int unsigned NUM_FP_REGS = 32,
    parameter int unsigned MAX_UOPS    = 17,
    parameter int unsigned OFS_W       = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid_i,
    output logic                    cmd_ready_o,
    input  logic [FIELD_W-1:0]      cmd_field_i,
    input  logic [REG_W-1:0]        cmd_reg_i,
    input  logic                    cmd_single_i,
    input  logic                    cmd_dir_i,
    input  logic                    cmd_wb_i,
    input  logic                    cmd_load_i,
    output logic                    uop_valid_o,
    input  logic                    uop_ready_i,
    output logic [1:0]              uop_kind_o,
    output logic [REG_W-1:0]        uop_reg_o,
    output logic signed [OFS_W-1:0] uop_ofs_o,
    output logic                    uop_last_o,
    output logic                    bad_count_o,
    output logic                    limit_hit_o
);
    import fpbt_pkg::*;

    localparam int unsigned XFER_W = $clog2(2 * NUM_FP_REGS + 1);
    localparam int unsigned TOT_W  = XFER_W + 1;

    seq_state_e state_q, state_d;

    logic                    cmd_fire;
    logic                    uop_fire;
    logic                    dec_bad;
    logic [XFER_W-1:0]       dec_nxfer;
    logic                    dec_wb;
    logic [TOT_W-1:0]        dec_emit;
    logic                    dec_limit;
    logic signed [OFS_W-1:0] dec_start;
    logic signed [OFS_W-1:0] dec_imm;

    logic [XFER_W-1:0]       xfer_left_q;
    logic [TOT_W-1:0]        remain_q;
    logic                    load_q;
    logic                    dir_q;
    logic signed [OFS_W-1:0] imm_q;
    logic                    bad_q;
    logic                    limit_q;

    logic [REG_W-1:0]        cur_reg;
    logic signed [OFS_W-1:0] cur_ofs;

    fpbt_count_decode #(
        .FIELD_W    (FIELD_W),
        .NUM_FP_REGS(NUM_FP_REGS),
        .MAX_UOPS   (MAX_UOPS),
        .OFS_W      (OFS_W)
    ) decode_i (
        .field_i    (cmd_field_i),
        .single_i   (cmd_single_i),
        .dir_i      (cmd_dir_i),
        .wb_i       (cmd_wb_i),
        .bad_o      (dec_bad),
        .nxfer_o    (dec_nxfer),
        .do_wb_o    (dec_wb),
        .emit_o     (dec_emit),
        .limit_hit_o(dec_limit),
        .start_ofs_o(dec_start),
        .imm_o      (dec_imm)
    );

    fpbt_walker #(
        .REG_W(REG_W),
        .OFS_W(OFS_W)
    ) walker_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cmd_fire),
        .step_i     (uop_fire && (state_q == ST_XFER)),
        .reg_start_i(cmd_reg_i),
        .ofs_start_i(dec_start),
        .reg_o      (cur_reg),
        .ofs_o      (cur_ofs)
    );

    assign cmd_fire = cmd_valid_i && cmd_ready_o;
    assign uop_fire = uop_valid_o && uop_ready_i;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_fire) begin
                    state_d = (dec_nxfer == '0) ? ST_BASE : ST_XFER;
                end
            end
            ST_XFER: begin
                if (uop_fire) begin
                    if (remain_q == TOT_W'(1)) begin
                        state_d = ST_IDLE;
                    end else if (xfer_left_q == XFER_W'(1)) begin
                        state_d = ST_BASE;
                    end
                end
            end
            ST_BASE: begin
                if (uop_fire) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and sequence bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            xfer_left_q <= '0;
            remain_q    <= '0;
            load_q      <= 1'b0;
            dir_q       <= 1'b0;
            imm_q       <= '0;
            bad_q       <= 1'b0;
            limit_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (cmd_fire) begin
                xfer_left_q <= dec_nxfer;
                remain_q    <= dec_emit;
                load_q      <= cmd_load_i;
                dir_q       <= cmd_dir_i;
                imm_q       <= dec_imm;
                bad_q       <= dec_bad;
                limit_q     <= dec_limit;
            end else if (uop_fire) begin
                remain_q <= remain_q - TOT_W'(1);
                if (state_q == ST_XFER) begin
                    xfer_left_q <= xfer_left_q - XFER_W'(1);
                end
            end
        end
    end

    // outputs
    always_comb begin
        cmd_ready_o = 1'b0;
        uop_valid_o = 1'b0;
        uop_kind_o  = UOP_LOAD_WORD;
        uop_reg_o   = '0;
        uop_ofs_o   = '0;
        uop_last_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cmd_ready_o = 1'b1;
            end
            ST_XFER: begin
                uop_valid_o = 1'b1;
                uop_kind_o  = load_q ? UOP_LOAD_WORD : UOP_STORE_WORD;
                uop_reg_o   = cur_reg;
                uop_ofs_o   = cur_ofs;
                uop_last_o  = (remain_q == TOT_W'(1));
            end
            ST_BASE: begin
                uop_valid_o = 1'b1;
                uop_kind_o  = dir_q ? UOP_BASE_ADD : UOP_BASE_SUB;
                uop_ofs_o   = imm_q;
                uop_last_o  = (remain_q == TOT_W'(1));
            end
            default: begin
                cmd_ready_o = 1'b0;
            end
        endcase
    end

    assign bad_count_o = bad_q;
    assign limit_hit_o = limit_q;

endmodule

// File: rtl/fp_block_xfer_seq_chk.sv
module fp_block_xfer_seq_chk #(
    parameter int unsigned FIELD_W     = 8,
    parameter int unsigned REG_W       = 5,
    parameter int unsigned NUM_FP_REGS = 32,
    parameter int unsigned MAX_UOPS    = 17,
    parameter int unsigned OFS_W       = 12
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cmd_valid_i,
    input logic                    cmd_ready_o,
    input logic [FIELD_W-1:0]      cmd_field_i,
    input logic [REG_W-1:0]        cmd_reg_i,
    input logic                    cmd_single_i,
    input logic                    cmd_dir_i,
    input logic                    cmd_wb_i,
    input logic                    cmd_load_i,
    input logic                    uop_valid_o,
    input logic                    uop_ready_i,
    input logic [1:0]              uop_kind_o,
    input logic [REG_W-1:0]        uop_reg_o,
    input logic signed [OFS_W-1:0] uop_ofs_o,
    input logic                    uop_last_o,
    input logic                    bad_count_o,
    input logic                    limit_hit_o
);

    logic cmd_fire;
    logic uop_fire;
    logic is_xfer;
    int unsigned ops_cnt;

    assign cmd_fire = cmd_valid_i && cmd_ready_o;
    assign uop_fire = uop_valid_o && uop_ready_i;
    assign is_xfer  = (uop_kind_o == 2'd0) || (uop_kind_o == 2'd1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ops_cnt <= 0;
        end else if (cmd_fire) begin
            ops_cnt <= 0;
        end else if (uop_fire) begin
            ops_cnt <= ops_cnt + 1;
        end
    end

    // R1
    uop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid_o && !uop_ready_i) |=> (uop_valid_o && $stable(uop_kind_o)
            && $stable(uop_reg_o) && $stable(uop_ofs_o) && $stable(uop_last_o)));

    // R1
    idle_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready_o |-> !uop_valid_o);

    // R9
    seq_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uop_fire |-> (ops_cnt < MAX_UOPS));

    // R10
    last_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_fire && uop_last_o) |=> cmd_ready_o);

    // R10
    accept_emits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_fire |=> uop_valid_o);

    // R6
    ofs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_fire && is_xfer && !uop_last_o) |=>
            (uop_valid_o && (!is_xfer || (uop_ofs_o == $past(uop_ofs_o) + OFS_W'(4)))));

    // R7
    reg_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_fire && is_xfer && !uop_last_o) |=>
            (uop_valid_o && (!is_xfer || (uop_reg_o == $past(uop_reg_o) + REG_W'(1)))));

    // R8
    base_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid_o && !is_xfer) |-> (uop_last_o && (uop_reg_o == '0)));

endmodule

bind fp_block_xfer_seq fp_block_xfer_seq_chk #(
    .FIELD_W    (FIELD_W),
    .REG_W      (REG_W),
    .NUM_FP_REGS(NUM_FP_REGS),
    .MAX_UOPS   (MAX_UOPS),
    .OFS_W      (OFS_W)
) chk_i (.*);

// File: tb/fp_block_xfer_seq_tb_top.sv
`timescale 1ns/1ps
module fp_block_xfer_seq_tb_top;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid_i = 1'b0;
    logic              cmd_ready_o;
    logic [7:0]        cmd_field_i = '0;
    logic [4:0]        cmd_reg_i = '0;
    logic              cmd_single_i = 1'b0;
    logic              cmd_dir_i = 1'b0;
    logic              cmd_wb_i = 1'b0;
    logic              cmd_load_i = 1'b0;
    logic              uop_valid_o;
    logic              uop_ready_i = 1'b0;
    logic [1:0]        uop_kind_o;
    logic [4:0]        uop_reg_o;
    logic signed [11:0] uop_ofs_o;
    logic              uop_last_o;
    logic              bad_count_o;
    logic              limit_hit_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    int exp_kind [0:79];
    int exp_reg  [0:79];
    int exp_ofs  [0:79];
    int exp_n;
    bit exp_bad;
    bit exp_lim;

    always #2.5 clk = ~clk;

    fp_block_xfer_seq dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid_i (cmd_valid_i),
        .cmd_ready_o (cmd_ready_o),
        .cmd_field_i (cmd_field_i),
        .cmd_reg_i   (cmd_reg_i),
        .cmd_single_i(cmd_single_i),
        .cmd_dir_i   (cmd_dir_i),
        .cmd_wb_i    (cmd_wb_i),
        .cmd_load_i  (cmd_load_i),
        .uop_valid_o (uop_valid_o),
        .uop_ready_i (uop_ready_i),
        .uop_kind_o  (uop_kind_o),
        .uop_reg_o   (uop_reg_o),
        .uop_ofs_o   (uop_ofs_o),
        .uop_last_o  (uop_last_o),
        .bad_count_o (bad_count_o),
        .limit_hit_o (limit_hit_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                checks++;
                errors++;
                $display("FAIL watchdog: got %0d cycles expected under %0d", cyc, 100000);
                finish_run();
            end
        end
    end

    // Expected sequence, derived from R2..R9
    task automatic build_expected(input int field, input int vreg, input bit single,
                                  input bit dir, input bit wb, input bit load);
        int elems_raw;
        int elems;
        int words;
        bit dowb;
        elems_raw = single ? field : field / 2;
        exp_bad   = (elems_raw == 0) || (elems_raw > 32);
        elems     = (elems_raw > 32) ? 32 : elems_raw;
        words     = single ? elems : 2 * elems;
        dowb      = wb || (elems_raw == 0);
        exp_lim   = (words + int'(dowb)) > 17;
        exp_n     = 0;
        for (int w = 0; w < words; w++) begin
            if (exp_n < 17) begin
                exp_kind[exp_n] = load ? 0 : 1;
                exp_reg[exp_n]  = (vreg + w) % 32;
                exp_ofs[exp_n]  = (dir ? -4 * field : 0) + 4 * w;
                exp_n++;
            end
        end
        if (dowb && exp_n < 17) begin
            exp_kind[exp_n] = dir ? 2 : 3;
            exp_reg[exp_n]  = 0;
            exp_ofs[exp_n]  = 4 * field;
            exp_n++;
        end
    endtask

    // Issue one command and collect its micro-ops. stall_mod > 0 drops ready
    // on every stall_mod-th cycle. busy_poke keeps offering a junk command.
    task automatic run_cmd(input string tag, input int field, input int vreg,
                           input bit single, input bit dir, input bit wb,
                           input bit load, input int stall_mod, input bit busy_poke);
        int got_n;
        int k;
        bit have_prev;
        int pk, pr, po, pl;
        bit seen_last;
        build_expected(field, vreg, single, dir, wb, load);
        @(negedge clk);
        cmd_field_i  = 8'(field);
        cmd_reg_i    = 5'(vreg);
        cmd_single_i = single;
        cmd_dir_i    = dir;
        cmd_wb_i     = wb;
        cmd_load_i   = load;
        cmd_valid_i  = 1'b1;
        chk(cmd_ready_o == 1'b1, "R1", {tag, " ready before accept"}, int'(cmd_ready_o), 1);
        got_n = 0;
        k = 0;
        have_prev = 1'b0;
        seen_last = 1'b0;
        pk = 0; pr = 0; po = 0; pl = 0;
        while (!seen_last && k < 300) begin
            @(negedge clk);
            if (busy_poke) begin
                cmd_valid_i  = 1'b1;
                cmd_field_i  = 8'd2;
                cmd_reg_i    = 5'd9;
                cmd_single_i = 1'b1;
                cmd_dir_i    = ~dir;
                cmd_wb_i     = 1'b1;
                cmd_load_i   = ~load;
            end else begin
                cmd_valid_i = 1'b0;
            end
            if (k == 0) begin
                chk(bad_count_o == exp_bad, "R3", {tag, " bad_count"}, int'(bad_count_o), int'(exp_bad));
                chk(limit_hit_o == exp_lim, "R9", {tag, " limit_hit"}, int'(limit_hit_o), int'(exp_lim));
                chk(uop_valid_o == 1'b1, "R10", {tag, " first uop valid"}, int'(uop_valid_o), 1);
            end
            if (busy_poke) begin
                chk(cmd_ready_o == 1'b0, "R1", {tag, " busy not ready"}, int'(cmd_ready_o), 0);
            end
            uop_ready_i = !(stall_mod > 0 && (k % stall_mod) == 1);
            if (have_prev) begin
                chk(uop_valid_o && int'(uop_kind_o) == pk && int'(uop_reg_o) == pr
                    && int'(uop_ofs_o) == po && int'(uop_last_o) == pl,
                    "R1", {tag, " hold under stall (ofs)"}, int'(uop_ofs_o), po);
                have_prev = 1'b0;
            end
            if (uop_valid_o) begin
                if (uop_ready_i) begin
                    if (got_n < exp_n) begin
                        chk(int'(uop_kind_o) == exp_kind[got_n], tag, "kind",
                            int'(uop_kind_o), exp_kind[got_n]);
                        chk(int'(uop_reg_o) == exp_reg[got_n], tag, "reg",
                            int'(uop_reg_o), exp_reg[got_n]);
                        chk(int'(uop_ofs_o) == exp_ofs[got_n], tag, "ofs",
                            int'(uop_ofs_o), exp_ofs[got_n]);
                        chk(uop_last_o == (got_n == exp_n - 1), "R10", {tag, " last flag"},
                            int'(uop_last_o), int'(got_n == exp_n - 1));
                    end
                    got_n++;
                    if (uop_last_o) seen_last = 1'b1;
                end else begin
                    have_prev = 1'b1;
                    pk = int'(uop_kind_o);
                    pr = int'(uop_reg_o);
                    po = int'(uop_ofs_o);
                    pl = int'(uop_last_o);
                end
            end
            k++;
        end
        chk(got_n == exp_n, "R9", {tag, " uop count"}, got_n, exp_n);
        @(negedge clk);
        cmd_valid_i = 1'b0;
        uop_ready_i = 1'b0;
        chk(cmd_ready_o == 1'b1, "R10", {tag, " ready after last"}, int'(cmd_ready_o), 1);
        chk(uop_valid_o == 1'b0, "R10", {tag, " idle after last"}, int'(uop_valid_o), 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(cmd_ready_o == 1'b1, "R11", "reset ready", int'(cmd_ready_o), 1);
        chk(uop_valid_o == 1'b0, "R11", "reset valid", int'(uop_valid_o), 0);
        chk(bad_count_o == 1'b0, "R11", "reset bad", int'(bad_count_o), 0);
        chk(limit_hit_o == 1'b0, "R11", "reset limit", int'(limit_hit_o), 0);
    endtask

    // R2 R6 R8: single load, base subtract
    task automatic t_single_load();
        run_cmd("R2 R6 R8 single load", 3, 2, 1'b1, 1'b0, 1'b1, 1'b1, 0, 1'b0);
    endtask

    // R7 R6: double store, negative start, index wraps past 31
    task automatic t_double_wrap();
        run_cmd("R7 R6 double wrap", 4, 30, 1'b0, 1'b1, 1'b0, 1'b0, 0, 1'b0);
    endtask

    // R5 R3: zero count forces base update
    task automatic t_zero_count();
        run_cmd("R5 R3 zero single", 0, 7, 1'b1, 1'b0, 1'b0, 1'b1, 0, 1'b0);
        run_cmd("R5 R3 zero double", 1, 3, 1'b0, 1'b1, 1'b0, 1'b0, 0, 1'b0);
    endtask

    // R4 R9: oversized count clamped and truncated
    task automatic t_clamp();
        run_cmd("R4 R9 clamp single", 40, 0, 1'b1, 1'b0, 1'b1, 1'b1, 0, 1'b0);
        run_cmd("R4 R9 clamp double", 70, 5, 1'b0, 1'b1, 1'b1, 1'b0, 0, 1'b0);
    endtask

    // R2 R8: odd field in double mode, base add, with stalls
    task automatic t_odd_double_stall();
        run_cmd("R2 R8 odd double stall", 5, 12, 1'b0, 1'b1, 1'b1, 1'b1, 3, 1'b0);
    endtask

    // R9: exactly at the limit, and one over it
    task automatic t_limit_edge();
        run_cmd("R9 at limit", 16, 1, 1'b1, 1'b0, 1'b1, 1'b0, 0, 1'b0);
        run_cmd("R9 over limit", 17, 1, 1'b1, 1'b1, 1'b1, 1'b0, 0, 1'b0);
    endtask

    // R1: commands offered while busy are ignored
    task automatic t_busy_ignore();
        run_cmd("R1 busy ignore", 6, 20, 1'b0, 1'b0, 1'b1, 1'b0, 2, 1'b1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single_load();
        t_double_wrap();
        t_zero_count();
        t_clamp();
        t_odd_double_stall();
        t_limit_edge();
        t_busy_ignore();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule